// File: doc/BRIEF.md
# Crossing Hit Frame Packer

This block gathers detector hits, one crossing at a time, and packs them into fixed 256-bit frames for a serial link. A hit names a strip, the time of the hit within the crossing on a 4-bit scale, and the board that saw it. The block puts each hit into a 15-bit record and places up to fourteen records in a frame. The frame also carries a hit count, the crossing number, the crossing-zero flag, a partition index and an end-of-data code. The low 24 bits hold a fixed placeholder where the line header and error-correction bits would normally go.

Hits arrive on a valid strobe. A separate one-cycle marker closes the crossing. When a crossing has more than fourteen hits, the block sends the frame it holds as a continuation frame and starts a new one. Every frame of that crossing carries the same crossing number, and the partition index counts up from zero. The index stops at 7. Hits that arrive after that are discarded, and a sticky flag records the loss. A crossing with no hits still sends one frame with a count of zero.

Top module: `hit_frame_packer`

## Requirements
- R1: Frame layout, counted from bit 0: placeholder [23:0], hit count [27:24], hit records from bit 28, crossing number [249:238], crossing-zero flag [250], partition index [253:251], end-of-data code [255:254].
- R2: Each 15-bit record holds the strip in its bits [6:0], the time code in [10:7] and the board number in [14:11].
- R3: Records appear in arrival order, with record k at bit 28+15k. The count field equals the number of records present. Record slots that are not used read as zero.
- R4: When the crossing-end marker is sampled, the next cycle shows a frame with end-of-data code 2'b01. A crossing with zero hits produces such a frame with count 0.
- R5: A hit that arrives while the held frame already has fourteen records sends that frame with code 2'b00 in the next cycle. The new hit becomes record 0 of the next frame.
- R6: All frames of one crossing carry the crossing number and crossing-zero flag sampled with the crossing's first hit (or with the end marker if there are no hits). The partition index is 0 in the first frame and rises by one in each continuation frame.
- R7: The partition index stops at 7, so at most 112 hits go out per crossing. Hits beyond that are discarded and set the overflow output, which stays high until reset.
- R8: The placeholder field always equals 24'h5AC3E1.
- R9: While reset is held, the frame valid output, the frame data and the overflow output are all zero.
- R10: The frame valid output is high for exactly one cycle for each frame the rules above call for, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_strip | input | 7 | Strip number, 1 to 96 |
| hit_sub | input | 4 | Time code within the crossing |
| hit_board | input | 4 | Board number |
| xing_end | input | 1 | One-cycle marker that closes the current crossing |
| xing_num | input | 12 | Crossing number |
| xing_bc0 | input | 1 | Crossing-zero flag |
| frame_valid | output | 1 | Frame output is valid this cycle |
| frame_data | output | 256 | Packed frame |
| hit_overflow | output | 1 | Sticky flag: hits were discarded |

## Verification
The assertions assume that the crossing-end marker never arrives in the same cycle as a hit. They also assume that the crossing number and crossing-zero flag stay stable from a crossing's first hit until its end marker. The stimulus keeps to both rules: it places the marker in a cycle of its own after the last hit, and it changes the crossing inputs only between crossings. Random crossings carry at most 40 hits. Only the final directed crossings go past 112 hits, so the check that the overflow flag stays low holds until then.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
   localparam int STRIP_W = 7;
   localparam int SUB_W   = 4;
   localparam int BOARD_W = 4;

   typedef struct packed {
      logic [BOARD_W-1:0] board;
      logic [SUB_W-1:0]   sub;
      logic [STRIP_W-1:0] strip;
   } hit_rec_t;

   localparam int REC_W = $bits(hit_rec_t);

   localparam logic [1:0] EOD_LAST = 2'b01;
   localparam logic [1:0] EOD_MORE = 2'b00;
endpackage

// File: rtl/hfp_rec_buf.sv
module hfp_rec_buf
   import hfp_pkg::*;
#(
   parameter int MAX_REC = 14,
   parameter int CNT_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      restart,
   input  logic                      clr,
   input  hit_rec_t                  rec_in,
   output hit_rec_t [MAX_REC-1:0]    recs,
   output logic     [CNT_W-1:0]      count
);
   for (genvar i = 0; i < MAX_REC; i++) begin : g_slot
      hit_rec_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (restart)
            slot_q <= (i == 0) ? rec_in : hit_rec_t'('0);
         else if (clr)
            slot_q <= '0;
         else if (wr_en && (count == CNT_W'(i)))
            slot_q <= rec_in;
      end
      assign recs[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (restart)
         count <= CNT_W'(1);
      else if (clr)
         count <= '0;
      else if (wr_en)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/hfp_part_ctl.sv
module hfp_part_ctl #(
   parameter int PART_W = 3,
   parameter int BCN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_seen,
   input  logic              spill,
   input  logic              done,
   input  logic              drop,
   input  logic [BCN_W-1:0]  bcn_in,
   input  logic              bc0_in,
   output logic [PART_W-1:0] part,
   output logic [BCN_W-1:0]  bcn_eff,
   output logic              bc0_eff,
   output logic              ovf
);
   logic             open_q;
   logic [BCN_W-1:0] bcn_q;
   logic             bc0_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         bcn_q  <= '0;
         bc0_q  <= 1'b0;
      end else if (done) begin
         open_q <= 1'b0;
      end else if (hit_seen && !open_q) begin
         open_q <= 1'b1;
         bcn_q  <= bcn_in;
         bc0_q  <= bc0_in;
      end
   end

   assign bcn_eff = open_q ? bcn_q : bcn_in;
   assign bc0_eff = open_q ? bc0_q : bc0_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         part <= '0;
      else if (done)
         part <= '0;
      else if (spill)
         part <= part + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (drop)
         ovf <= 1'b1;
   end
endmodule

// File: rtl/hfp_frame_fmt.sv
module hfp_frame_fmt
   import hfp_pkg::*;
#(
   parameter int              FRAME_W = 256,
   parameter int              HDR_W   = 24,
   parameter int              CNT_W   = 4,
   parameter int              BCN_W   = 12,
   parameter int              PART_W  = 3,
   parameter int              EOD_W   = 2,
   parameter int              MAX_REC = 14,
   parameter logic [HDR_W-1:0] HDR_PAT = 'h5AC3E1
) (
   input  hit_rec_t [MAX_REC-1:0] recs,
   input  logic [CNT_W-1:0]       count,
   input  logic [BCN_W-1:0]       bcn,
   input  logic                   bc0,
   input  logic [PART_W-1:0]      part,
   input  logic [EOD_W-1:0]       eod,
   output logic [FRAME_W-1:0]     frame
);
   localparam int CNT_LSB  = HDR_W;
   localparam int REC_LSB  = HDR_W + CNT_W;
   localparam int EOD_LSB  = FRAME_W - EOD_W;
   localparam int PART_LSB = EOD_LSB - PART_W;
   localparam int BC0_POS  = PART_LSB - 1;
   localparam int BCN_LSB  = BC0_POS - BCN_W;

   always_comb begin
      frame = '0;
      frame[0 +: HDR_W]         = HDR_PAT;
      frame[CNT_LSB +: CNT_W]   = count;
      for (int i = 0; i < MAX_REC; i++)
         frame[REC_LSB + i*REC_W +: REC_W] = recs[i];
      frame[BCN_LSB +: BCN_W]   = bcn;
      frame[BC0_POS]            = bc0;
      frame[PART_LSB +: PART_W] = part;
      frame[EOD_LSB +: EOD_W]   = eod;
   end
endmodule

// File: rtl/hit_frame_packer.sv
module hit_frame_packer
   import hfp_pkg::*;
#(
   parameter int               FRAME_W     = 256,
   parameter int               HDR_W       = 24,
   parameter int               CNT_W       = 4,
   parameter int               BCN_W       = 12,
   parameter int               PART_W      = 3,
   parameter int               EOD_W       = 2,
   parameter logic [HDR_W-1:0] HDR_PAT     = 'h5AC3E1,
   parameter bit               EMPTY_FRAME = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit_valid,
   input  logic [STRIP_W-1:0]   hit_strip,
   input  logic [SUB_W-1:0]     hit_sub,
   input  logic [BOARD_W-1:0]   hit_board,
   input  logic                 xing_end,
   input  logic [BCN_W-1:0]     xing_num,
   input  logic                 xing_bc0,
   output logic                 frame_valid,
   output logic [FRAME_W-1:0]   frame_data,
   output logic                 hit_overflow
);
   localparam int OVH      = HDR_W + CNT_W + BCN_W + 1 + PART_W + EOD_W;
   localparam int MAX_REC  = (FRAME_W - OVH) / REC_W;
   localparam int PART_MAX = (1 << PART_W) - 1;

   if (MAX_REC < 1) begin : g_err_small
      $error("frame too narrow for a single hit record");
   end
   if (MAX_REC > (1 << CNT_W) - 1) begin : g_err_cnt
      $error("hit count field cannot hold the record capacity");
   end
   if (EOD_W < 2) begin : g_err_eod
      $error("end-of-data field needs two bits");
   end

   hit_rec_t [MAX_REC-1:0] recs;
   logic [CNT_W-1:0]       count;
   logic [PART_W-1:0]      part;
   logic [BCN_W-1:0]       bcn_eff;
   logic                   bc0_eff;
   logic [FRAME_W-1:0]     frame_nxt;
   hit_rec_t               rec_in;
   logic                   full, at_last, accept, spill, drop, end_emit, emit;
   logic [EOD_W-1:0]       eod;

   assign rec_in  = '{board: hit_board, sub: hit_sub, strip: hit_strip};
   assign full    = (count == CNT_W'(MAX_REC));
   assign at_last = (part == PART_W'(PART_MAX));
   assign accept  = hit_valid && !full;
   assign spill   = hit_valid && full && !at_last;
   assign drop    = hit_valid && full && at_last;
   assign eod     = xing_end ? EOD_W'(EOD_LAST) : EOD_W'(EOD_MORE);

   if (EMPTY_FRAME) begin : g_empty_sent
      assign end_emit = xing_end;
   end else begin : g_empty_quiet
      assign end_emit = xing_end && (count != '0);
   end

   assign emit = spill || end_emit;

   hfp_rec_buf #(
      .MAX_REC (MAX_REC),
      .CNT_W   (CNT_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .restart (spill),
      .clr     (xing_end),
      .rec_in  (rec_in),
      .recs    (recs),
      .count   (count)
   );

   hfp_part_ctl #(
      .PART_W (PART_W),
      .BCN_W  (BCN_W)
   ) u_part (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_seen (accept || spill),
      .spill    (spill),
      .done     (xing_end),
      .drop     (drop),
      .bcn_in   (xing_num),
      .bc0_in   (xing_bc0),
      .part     (part),
      .bcn_eff  (bcn_eff),
      .bc0_eff  (bc0_eff),
      .ovf      (hit_overflow)
   );

   hfp_frame_fmt #(
      .FRAME_W (FRAME_W),
      .HDR_W   (HDR_W),
      .CNT_W   (CNT_W),
      .BCN_W   (BCN_W),
      .PART_W  (PART_W),
      .EOD_W   (EOD_W),
      .MAX_REC (MAX_REC),
      .HDR_PAT (HDR_PAT)
   ) u_fmt (
      .recs  (recs),
      .count (count),
      .bcn   (bcn_eff),
      .bc0   (bc0_eff),
      .part  (part),
      .eod   (eod),
      .frame (frame_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         frame_data  <= '0;
      end else begin
         frame_valid <= emit;
         if (emit)
            frame_data <= frame_nxt;
      end
   end
endmodule

// File: rtl/hfp_checker.sv
module hfp_checker #(
   parameter int               FRAME_W = 256,
   parameter int               HDR_W   = 24,
   parameter int               CNT_W   = 4,
   parameter int               EOD_W   = 2,
   parameter int               MAX_REC = 14,
   parameter logic [HDR_W-1:0] HDR_PAT = 'h5AC3E1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hit_valid,
   input logic               xing_end,
   input logic               frame_valid,
   input logic [FRAME_W-1:0] frame_data,
   input logic               hit_overflow
);
   localparam int EOD_LSB = FRAME_W - EOD_W;

   // input rule: end marker stands alone
   a_r4_end_alone: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && xing_end));

   a_r4_end_frame: assert property (@(posedge clk) disable iff (!rst_n)
      xing_end |=> frame_valid && (frame_data[EOD_LSB +: EOD_W] == EOD_W'(1)));

   a_r5_more_full: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_data[EOD_LSB +: EOD_W] == '0)
         |-> frame_data[HDR_W +: CNT_W] == CNT_W'(MAX_REC));

   a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> frame_data[HDR_W +: CNT_W] <= CNT_W'(MAX_REC));

   a_r8_header: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> frame_data[0 +: HDR_W] == HDR_PAT);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hit_overflow |=> hit_overflow);

   a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(hit_valid || xing_end));
endmodule

bind hit_frame_packer hfp_checker #(
   .FRAME_W (FRAME_W),
   .HDR_W   (HDR_W),
   .CNT_W   (CNT_W),
   .EOD_W   (EOD_W),
   .MAX_REC (MAX_REC),
   .HDR_PAT (HDR_PAT)
) u_hfp_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .hit_valid    (hit_valid),
   .xing_end     (xing_end),
   .frame_valid  (frame_valid),
   .frame_data   (frame_data),
   .hit_overflow (hit_overflow)
);

// File: tb/hit_frame_packer_bench.sv
`timescale 1ns/1ps
module hit_frame_packer_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hit_valid = 1'b0;
   logic [6:0]   hit_strip = '0;
   logic [3:0]   hit_sub = '0;
   logic [3:0]   hit_board = '0;
   logic         xing_end = 1'b0;
   logic [11:0]  xing_num = '0;
   logic         xing_bc0 = 1'b0;
   logic         frame_valid;
   logic [255:0] frame_data;
   logic         hit_overflow;

   always #10 clk = ~clk;

   hit_frame_packer u_hit_frame_packer (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_strip(hit_strip),
      .hit_sub(hit_sub), .hit_board(hit_board), .xing_end(xing_end),
      .xing_num(xing_num), .xing_bc0(xing_bc0), .frame_valid(frame_valid),
      .frame_data(frame_data), .hit_overflow(hit_overflow)
   );

   int           total = 0;
   int           bad = 0;
   bit           exp_ovf = 1'b0;
   logic [14:0]  hit_mem [0:127];
   logic [255:0] expq [$];

   task automatic chk(input bit ok, input string tag,
                      input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [255:0] mk(input int first, input int cnt,
         input logic [11:0] b, input logic b0, input int p, input logic [1:0] e);
      logic [255:0] f;
      f = '0;
      f[23:0]    = 24'h5AC3E1;
      f[27:24]   = cnt[3:0];
      for (int k = 0; k < cnt; k++)
         f[28 + 15*k +: 15] = hit_mem[first + k];
      f[249:238] = b;
      f[250]     = b0;
      f[253:251] = p[2:0];
      f[255:254] = e;
      return f;
   endfunction

   // frame monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n && frame_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R10 frame with none expected", frame_data, '0);
         end else begin
            logic [255:0] e;
            e = expq.pop_front();
            chk(frame_data[23:0] == e[23:0], "R8 placeholder", frame_data, e);
            chk(frame_data[27:24] == e[27:24], "R3 hit count", frame_data, e);
            chk(frame_data[237:28] == e[237:28], "R2 record fields", frame_data, e);
            chk(frame_data[250:238] == e[250:238], "R1 R6 crossing number", frame_data, e);
            chk(frame_data[253:251] == e[253:251],
                (e[253:251] == 3'd7) ? "R7 partition cap" : "R6 partition index",
                frame_data, e);
            chk(frame_data[255:254] == e[255:254],
                (e[255:254] == 2'b01) ? "R4 final code" : "R5 continuation code",
                frame_data, e);
         end
      end
   end

   task automatic run_xing(input int n, input int gap_max);
      logic [11:0] b;
      logic        b0;
      int          kept, frames, cnt;
      b    = 12'($urandom);
      b0   = ($urandom % 8) == 0;
      kept = (n > 112) ? 112 : n;
      for (int i = 0; i < n; i++)
         hit_mem[i] = {4'($urandom), 4'($urandom), 7'(1 + $urandom % 96)};
      frames = (kept == 0) ? 1 : (kept + 13) / 14;
      for (int fi = 0; fi < frames; fi++) begin
         cnt = kept - 14*fi;
         if (cnt > 14) cnt = 14;
         expq.push_back(mk(14*fi, cnt, b, b0, fi, (fi == frames-1) ? 2'b01 : 2'b00));
      end
      if (n > 112) exp_ovf = 1'b1;
      @(negedge clk);
      xing_num = b;
      xing_bc0 = b0;
      for (int i = 0; i < n; i++) begin
         repeat ($urandom % (gap_max + 1)) @(negedge clk);
         hit_valid = 1'b1;
         {hit_board, hit_sub, hit_strip} = hit_mem[i];
         @(negedge clk);
         hit_valid = 1'b0;
      end
      xing_end = 1'b1;
      @(negedge clk);
      xing_end = 1'b0;
      @(negedge clk);
      chk(hit_overflow == exp_ovf, "R7 overflow flag",
          256'(hit_overflow), 256'(exp_ovf));
      xing_num = 12'($urandom);
      xing_bc0 = $urandom % 2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired R10");
      total++;
      bad++;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(frame_valid == 1'b0, "R9 valid in reset", 256'(frame_valid), '0);
      chk(frame_data == '0, "R9 data in reset", frame_data, '0);
      chk(hit_overflow == 1'b0, "R9 overflow in reset", 256'(hit_overflow), '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(frame_valid == 1'b0, "R10 idle after reset", 256'(frame_valid), '0);

      run_xing(0, 0);    // R4 empty crossing
      run_xing(1, 0);
      run_xing(14, 0);   // R3 exactly full
      run_xing(15, 0);   // R5 first spill
      run_xing(20, 1);   // R6 two partitions
      run_xing(28, 0);
      run_xing(29, 2);
      run_xing(112, 0);  // R7 last partition, no loss
      for (int c = 0; c < 150; c++)
         run_xing($urandom % 41, $urandom % 3);
      run_xing(120, 1);  // R7 hits discarded
      run_xing(3, 0);    // R7 flag stays set
      run_xing(0, 0);

      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R10 frames missing", 256'(expq.size()), '0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule